// File: doc/BRIEF.md
# Table-Driven Wide-Step Signature Compactor

This block compacts a bit stream into the signature of a 32-bit internal-XOR single-input signature register. It does not shift one bit per clock. It retires a whole 64-bit word per clock by looking up the contribution of each byte of the current state and each byte of the word's upper half. Each lookup gives a 32-bit term, and the block XORs all the terms together. The lower 32 bits of the word need no table: their polynomial degree is already below the register length, so they are XORed straight into the result. All tables are computed at elaboration from the characteristic polynomial parameter. The x^32 term of that polynomial is implied, and the parameter holds the lower 32 coefficients. A byte that is zero skips its lookup and adds nothing.

A user pulses `start` while the block is idle, then streams words over a valid/ready handshake. The first bit of the stream is bit 63 of the first word. The final word carries `in_last` and a length field for streams whose length is not a whole number of words. A partial final word is retired one byte per clock through a byte-step table. The signature is then presented with a one-cycle `done` pulse. From a zero start, the signature equals the stream polynomial modulo the characteristic polynomial over GF(2).

The controller has four states:
- IDLE: waits for `start`.
- RUN: accepts words.
- TAIL: drains the bytes of a partial last word.
- DONE: one cycle that raises `done`.

It has these transitions:
- IDLE→RUN on `start`.
- RUN→DONE on a full last word.
- RUN→TAIL on a partial last word.
- TAIL→DONE when the final byte is taken.
- DONE→IDLE unconditionally.

Top module: `sigc_compactor`

## Requirements
- R1: After reset, `sig` is zero, and both `done` and `in_ready` are low (state IDLE).
- R2: A `start` pulse in IDLE clears `sig` to zero and raises `in_ready` on the next cycle.
- R3: In RUN, every word accepted without `in_last` sets `sig` to (S·x^64 + D) mod P in the next cycle. Here S is the old `sig`, and D is the word with bit 63 as the highest-degree coefficient. A cycle with `in_valid` low leaves `sig` unchanged.
- R4: The low 32 bits of a word enter the result unchanged: from a zero state, a word whose upper 32 bits are zero gives `sig` equal to its low 32 bits.
- R5: The final signature equals the whole stream polynomial modulo x^32 + P, for each value of the polynomial parameter. A single word equal to 2^32 yields `sig` = P.
- R6: On the last word, `in_len` = k (1..7) means that only the top k bytes, bits 63 down to 64−8k, belong to the stream. The remaining bits are ignored. `in_len` = 0 means a full word.
- R7: `done` rises k cycles after the acceptance cycle of a last word with `in_len` = k, where k = 0 for a full word. `in_ready` stays low during the tail.
- R8: `done` lasts exactly one cycle. It is followed by IDLE with `in_ready` low and `sig` holding the signature.
- R9: `start` asserted while in RUN is ignored, and the stream's signature is unaffected.
- R10: In IDLE without `start`, `in_valid` and `in_data` are ignored: `sig` holds and `in_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Clears the signature and opens a stream (honoured in IDLE only) |
| in_valid | input | 1 | Word on `in_data` is valid |
| in_ready | output | 1 | Block accepts a word this cycle |
| in_data | input | 64 | Stream word, bit 63 first in time |
| in_last | input | 1 | Word is the final one of the stream |
| in_len | input | 3 | Bytes used from the last word (0 = all eight) |
| sig | output | 32 | Current / final signature |
| done | output | 1 | One-cycle pulse: signature is final |

## Verification
Two copies of the block with different polynomials receive the same stimulus. Each is compared against a bit-serial internal-XOR register model, which separates table-content errors from polynomial-specific errors. Directed words are used to isolate single paths:
- A word with only low bits set isolates the direct path.
- The word 2^32 isolates the first input table.
- An all-zero stream exercises the zero bypass.
- A one-byte tail isolates the byte step.

Random streams of one to six words, with every tail length, idle gaps and a mid-stream `start`, check the chaining of state tables, the ignoring of the tail's low bytes and the completion latency.

// File: rtl/sigc_pkg.sv
package sigc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_TAIL,
        ST_DONE
    } sigc_state_e;
endpackage

// File: rtl/sigc_rom.sv
// Elaboration-computed lookup table: val = (idx(x) * x^SHIFT) mod (x^W + POLY)
module sigc_rom #(
    parameter int           W     = 32,
    parameter int           PW    = 8,
    parameter int           SHIFT = 32,
    parameter logic [W-1:0] POLY  = 32'h04C11DB7
) (
    input  logic [PW-1:0] idx,
    output logic [W-1:0]  val
);
    localparam int N = 1 << PW;

    function automatic logic [N*W-1:0] build_tbl();
        logic [W-1:0]   basis [PW];
        logic [W-1:0]   v;
        logic [W-1:0]   acc;
        logic [N*W-1:0] t;
        v = W'(1);
        for (int k = 0; k < SHIFT; k++)
            v = {v[W-2:0], 1'b0} ^ (v[W-1] ? POLY : '0);
        for (int i = 0; i < PW; i++) begin
            basis[i] = v;
            v = {v[W-2:0], 1'b0} ^ (v[W-1] ? POLY : '0);
        end
        t = '0;
        for (int e = 0; e < N; e++) begin
            acc = '0;
            for (int i = 0; i < PW; i++)
                if (e[i]) acc = acc ^ basis[i];
            t[e*W +: W] = acc;
        end
        return t;
    endfunction

    localparam logic [N*W-1:0] TBL = build_tbl();

    assign val = TBL[int'(idx)*W +: W];
endmodule

// File: rtl/sigc_wide_step.sv
// One wide step: next = (state * x^IN_W + data) mod P
module sigc_wide_step #(
    parameter int               SIG_W = 32,
    parameter int               IN_W  = 64,
    parameter int               PW    = 8,
    parameter logic [SIG_W-1:0] POLY  = 32'h04C11DB7
) (
    input  logic [SIG_W-1:0] state,
    input  logic [IN_W-1:0]  data,
    output logic [SIG_W-1:0] next_state
);
    localparam int NSP = SIG_W / PW;
    localparam int NIP = (IN_W - SIG_W) / PW;

    logic [SIG_W-1:0] s_term [NSP];
    logic [SIG_W-1:0] i_term [NIP];

    for (genvar j = 0; j < NSP; j++) begin : g_state
        logic [PW-1:0]    key;
        logic [SIG_W-1:0] look;
        assign key = state[PW*j +: PW];
        sigc_rom #(.W(SIG_W), .PW(PW), .SHIFT(IN_W + PW*j), .POLY(POLY)) u_rom (
            .idx(key), .val(look));
        assign s_term[j] = (key == '0) ? '0 : look;
    end

    for (genvar j = 0; j < NIP; j++) begin : g_input
        logic [PW-1:0]    key;
        logic [SIG_W-1:0] look;
        assign key = data[SIG_W + PW*j +: PW];
        sigc_rom #(.W(SIG_W), .PW(PW), .SHIFT(SIG_W + PW*j), .POLY(POLY)) u_rom (
            .idx(key), .val(look));
        assign i_term[j] = (key == '0) ? '0 : look;
    end

    always_comb begin
        next_state = data[SIG_W-1:0];
        for (int j = 0; j < NSP; j++) next_state = next_state ^ s_term[j];
        for (int j = 0; j < NIP; j++) next_state = next_state ^ i_term[j];
    end
endmodule

// File: rtl/sigc_byte_step.sv
// One narrow step: next = (state * x^PW + byte_in) mod P
module sigc_byte_step #(
    parameter int               SIG_W = 32,
    parameter int               PW    = 8,
    parameter logic [SIG_W-1:0] POLY  = 32'h04C11DB7
) (
    input  logic [SIG_W-1:0] state,
    input  logic [PW-1:0]    byte_in,
    output logic [SIG_W-1:0] next_state
);
    logic [PW-1:0]    top;
    logic [SIG_W-1:0] look;

    assign top = state[SIG_W-1 -: PW];

    sigc_rom #(.W(SIG_W), .PW(PW), .SHIFT(SIG_W), .POLY(POLY)) u_rom (
        .idx(top), .val(look));

    assign next_state = {state[SIG_W-PW-1:0], byte_in} ^ ((top == '0) ? '0 : look);
endmodule

// File: rtl/sigc_compactor.sv
module sigc_compactor #(
    parameter int               SIG_W = 32,
    parameter int               IN_W  = 64,
    parameter int               PW    = 8,
    parameter logic [SIG_W-1:0] POLY  = 32'h04C11DB7
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             start,
    input  logic                             in_valid,
    output logic                             in_ready,
    input  logic [IN_W-1:0]                  in_data,
    input  logic                             in_last,
    input  logic [$clog2(IN_W/PW)-1:0]       in_len,
    output logic [SIG_W-1:0]                 sig,
    output logic                             done
);
    import sigc_pkg::*;

    localparam int LEN_W = $clog2(IN_W / PW);

    sigc_state_e      st_q, st_d;
    logic [SIG_W-1:0] sig_q;
    logic [IN_W-1:0]  buf_q;
    logic [LEN_W-1:0] cnt_q;
    logic [SIG_W-1:0] wide_next, byte_next;
    logic             take;

    assign take = (st_q == ST_RUN) && in_valid;

    sigc_wide_step #(.SIG_W(SIG_W), .IN_W(IN_W), .PW(PW), .POLY(POLY)) u_wide (
        .state(sig_q), .data(in_data), .next_state(wide_next));

    sigc_byte_step #(.SIG_W(SIG_W), .PW(PW), .POLY(POLY)) u_byte (
        .state(sig_q), .byte_in(buf_q[IN_W-1 -: PW]), .next_state(byte_next));

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (start) st_d = ST_RUN;
            ST_RUN:  if (take && in_last) st_d = (in_len == '0) ? ST_DONE : ST_TAIL;
            ST_TAIL: if (cnt_q == LEN_W'(1)) st_d = ST_DONE;
            ST_DONE: st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sig_q <= '0;
            buf_q <= '0;
            cnt_q <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (start) sig_q <= '0;
                ST_RUN: if (take) begin
                    if (in_last && in_len != '0) begin
                        buf_q <= in_data;
                        cnt_q <= in_len;
                    end else begin
                        sig_q <= wide_next;
                    end
                end
                ST_TAIL: begin
                    sig_q <= byte_next;
                    buf_q <= {buf_q[IN_W-PW-1:0], {PW{1'b0}}};
                    cnt_q <= cnt_q - 1'b1;
                end
                ST_DONE: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        in_ready = (st_q == ST_RUN);
        done     = (st_q == ST_DONE);
        sig      = sig_q;
    end
endmodule

// File: rtl/sigc_checker.sv
module sigc_checker #(
    parameter int SIG_W = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start,
    input logic                   in_valid,
    input logic                   in_ready,
    input logic                   done,
    input logic [SIG_W-1:0]       sig,
    input sigc_pkg::sigc_state_e  st
);
    import sigc_pkg::*;

    // R2: start in IDLE clears the signature and opens the stream
    a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && start) |=> (sig == '0 && in_ready));

    // R3: a RUN cycle without a word keeps the signature
    a_r3_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> $stable(sig));

    // R7: no word accepted while the tail drains
    a_r7_tail_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_TAIL) |-> !in_ready);

    // R8: done is a single-cycle pulse, followed by IDLE with the result held
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r8_done_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!in_ready && st == ST_IDLE));
    a_r8_sig_hold: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> $stable(sig));

    // R10: idle without start ignores the input side
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !start) |=> ($stable(sig) && !in_ready));
endmodule

bind sigc_compactor sigc_checker #(.SIG_W(SIG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .in_ready(in_ready), .done(done), .sig(sig), .st(st_q));

// File: tb/tb_sigc_compactor.sv
module tb_sigc_compactor;
    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] P_A = 32'h04C11DB7;
    localparam logic [31:0] P_B = 32'h8F3A2C15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_data = '0;
    logic        in_last = 1'b0;
    logic [2:0]  in_len = '0;
    logic        in_ready, done, ready_b, done_b;
    logic [31:0] sig, sig_b;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [63:0] msg [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    sigc_compactor #(.POLY(P_A)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_last(in_last), .in_len(in_len), .sig(sig), .done(done));

    sigc_compactor #(.POLY(P_B)) dut_b (
        .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid), .in_ready(ready_b),
        .in_data(in_data), .in_last(in_last), .in_len(in_len), .sig(sig_b), .done(done_b));

    function automatic logic [31:0] ser(input logic [31:0] s, input logic [31:0] poly,
                                        input logic [63:0] d, input int nb);
        logic fb;
        for (int i = nb - 1; i >= 0; i--) begin
            fb = s[31];
            s  = {s[30:0], d[i]} ^ (fb ? poly : 32'h0);
        end
        return s;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<=100000 cycles", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
            $finish;
        end
    end

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // stream nw words from msg[]; lastlen = in_len of the last word
    task automatic run_msg(input int nw, input int lastlen, input bit start_mid, input bit gaps);
        logic [31:0] ea, eb, held;
        int wait_cyc;
        ea = '0; eb = '0;
        pulse_start();
        for (int w = 0; w < nw; w++) begin
            if (gaps && ($urandom % 3 == 0)) begin
                in_valid = 1'b0;
                held = sig;
                @(negedge clk);
                chk("R3 stall", sig, held);
            end
            in_valid = 1'b1;
            in_data  = msg[w];
            in_last  = (w == nw - 1);
            in_len   = (w == nw - 1) ? 3'(lastlen) : 3'(0);
            start    = start_mid && (w == 1);
            @(negedge clk);
            start = 1'b0;
            if (w != nw - 1) begin
                ea = ser(ea, P_A, msg[w], 64);
                eb = ser(eb, P_B, msg[w], 64);
                chk("R3 word step A", sig, ea);
                chk("R3 word step B", sig_b, eb);
            end else if (lastlen == 0) begin
                ea = ser(ea, P_A, msg[w], 64);
                eb = ser(eb, P_B, msg[w], 64);
            end else begin
                ea = ser(ea, P_A, msg[w] >> (64 - 8*lastlen), 8*lastlen);
                eb = ser(eb, P_B, msg[w] >> (64 - 8*lastlen), 8*lastlen);
            end
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        in_len   = '0;
        wait_cyc = 0;
        while (!done && wait_cyc < 20) begin
            chk("R7 ready low in tail", 32'(in_ready), 32'd0);
            @(negedge clk);
            wait_cyc++;
        end
        chk("R7 done latency", 32'(wait_cyc), 32'(lastlen));
        chk(start_mid ? "R9 R5 R6 signature A" : "R5 R6 signature A", sig, ea);
        chk(start_mid ? "R9 R5 R6 signature B" : "R5 R6 signature B", sig_b, eb);
        @(negedge clk);
        chk("R8 done one cycle", 32'(done), 32'd0);
        chk("R8 idle not ready", 32'(in_ready), 32'd0);
        chk("R8 sig held", sig, ea);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 sig", sig, 32'h0);
        chk("R1 done", 32'(done), 32'd0);
        chk("R1 ready", 32'(in_ready), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 idle input ignored
        in_valid = 1'b1; in_data = 64'hFFFF_0000_1234_5678; in_last = 1'b1;
        @(negedge clk);
        chk("R10 sig ignored", sig, 32'h0);
        chk("R10 ready low", 32'(in_ready), 32'd0);
        in_valid = 1'b0; in_last = 1'b0;

        // R2 start clears
        pulse_start();
        chk("R2 sig zero", sig, 32'h0);
        chk("R2 ready", 32'(in_ready), 32'd1);
        @(negedge clk);

        // R4 direct low path
        msg[0] = 64'h0000_0000_DEAD_BEEF;
        run_msg(1, 0, 1'b0, 1'b0);
        chk("R4 direct low A", sig, 32'hDEAD_BEEF);
        chk("R4 direct low B", sig_b, 32'hDEAD_BEEF);

        // R5 x^32 mod P = P
        msg[0] = 64'h0000_0001_0000_0000;
        run_msg(1, 0, 1'b0, 1'b0);
        chk("R5 x32 A", sig, P_A);
        chk("R5 x32 B", sig_b, P_B);

        // zero stream
        msg[0] = '0; msg[1] = '0; msg[2] = '0;
        run_msg(3, 0, 1'b0, 1'b0);
        chk("R5 zero stream", sig, 32'h0);

        // R6 one-byte tail holding 1, low bytes are garbage
        msg[0] = 64'h01FF_FFFF_FFFF_FFFF;
        run_msg(1, 1, 1'b0, 1'b0);
        chk("R6 single byte A", sig, 32'h1);

        // R6 seven-byte tail
        msg[0] = 64'h0123_4567_89AB_CDEF;
        msg[1] = 64'hFEDC_BA98_7654_3210;
        run_msg(2, 7, 1'b0, 1'b0);

        // random streams
        for (int t = 0; t < 40; t++) begin
            int nw;
            nw = 1 + ($urandom % 6);
            for (int w = 0; w < nw; w++) msg[w] = {$urandom, $urandom};
            run_msg(nw, t % 8, (t % 5 == 0) && nw > 1, (t % 2 == 1));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule